// File: doc/BRIEF.md
# Dual-Channel Receive Byte Buffer

This block collects the bit streams of two serial receivers, called channel A and channel B, and hands them to a host one byte at a time. A shared `bit_tick` strobe marks each bit time. On a tick, each channel either offers a qualified bit or offers nothing. Qualified bits are packed MSB first into a byte. When the byte is complete, or when the channel goes quiet for a programmed number of bit times, the byte moves into that channel's host-visible data register.

An 8-bit status word records four things per channel:
- a byte has arrived;
- the frame has ended;
- an overflow or underflow has occurred;
- whether the last loaded byte was complete.

The status word clears when read, so the host can run by polling. As an alternative, the host can set an enable mask and wait on `irq`. While `rx_en` is low, both channels and all status are held cleared.

Each channel runs a two-state machine:
- **LN_WAIT**: no frame is in progress.
- **LN_RECV**: a frame is being received.

There are two transitions:
- **START**: LN_WAIT goes to LN_RECV on the first qualified bit.
- **TIMEOUT**: LN_RECV goes to LN_WAIT when the idle bit count reaches the limit.

Dropping `rx_en` forces both channels to LN_WAIT.

Top module: `rx_byte_hub`

## Requirements
- R1: After reset, and for as long as `rx_en` is low, the status word reads 0x00, `irq` is 0 and the data registers read 0x00. Dropping `rx_en` discards every held byte and status bit.
- R2: Qualified bits are packed MSB first. On the tick that carries the eighth bit:
  - the byte appears in the channel's data register (address 1 for A, address 2 for B);
  - Full is set (status bit 0 for A, bit 4 for B);
  - Valid is set (bit 3 for A, bit 7 for B).
- R3: Overflow sets Flow Violation (bit 2 for A, bit 6 for B). Overflow means a byte is loaded while the register still holds an unread byte. The register then keeps the newer byte.
- R4: Underflow also sets that channel's Flow Violation bit. Underflow means a host read of a data register that holds no unread byte.
- R5: End of frame is declared once a frame has started and `idle_limit` consecutive ticks pass without a qualified bit; a limit of 0 acts as 1. At end of frame:
  - EOF is set (bit 1 for A, bit 5 for B);
  - any partial byte is loaded left-justified, with its unfilled low bits zero;
  - Full is set and Valid is cleared.
- R6: After end of frame, idle ticks cause no further EOF until a qualified bit starts a new frame.
- R7: Reading the status word (address 0) clears the Full, EOF and Flow Violation bits. A set event in the same cycle as the read wins.
- R8: Reading a data register returns its byte, clears that channel's Full bit and marks the register empty.
- R9: Status bits set whatever the enable mask holds. `irq` is the OR of the enabled Full, EOF and Flow Violation bits; the Valid bits (3 and 7) never drive `irq`.
- R10: Address 3 holds the 8-bit interrupt enable mask. It is written by `host_wr`, reads back as written, and resets to 0x00.
- R11: Each channel's events affect only that channel's status bits and data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive mode; low holds both channels and the status word clear |
| bit_tick | input | 1 | One-cycle strobe marking a bit time |
| rx_bit | input | 2 | Received bit; index 0 is channel A, index 1 is channel B |
| rx_vld | input | 2 | Per-channel qualifier for `rx_bit` on a tick |
| idle_limit | input | IDLE_W | Idle bit times that end a frame |
| host_addr | input | 2 | Register address: 0 status, 1 data A, 2 data B, 3 enable |
| host_rd | input | 1 | Read strobe; its side effects take place at the clock edge |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from `host_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the cycle in which a byte completes while the host reads the status word. A design that let the clear win would lose the Full bit, and the bench reads it back. It drives an idle timeout with a partial byte to check left justification and the cleared Valid flag. It then adds further idle ticks, where a design that kept its timer running would raise a second EOF. Underflow and overflow are each provoked on their own channel, so that a design which swaps channels or drops the newer byte shows a wrong bit or byte. An enable mask that covers only the Valid positions must leave `irq` low.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam int BYTE_W  = 8;
    localparam int NUM_CH  = 2;
    localparam int ADDR_W  = 2;
    localparam int FIELD_W = 4;
    localparam int ST_W    = NUM_CH * FIELD_W;

    localparam logic [ADDR_W-1:0] ADR_STAT   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_DATA_A = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_DATA_B = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_IRQ_EN = 2'd3;

    localparam int OFS_FULL  = 0;
    localparam int OFS_EOF   = 1;
    localparam int OFS_FLOW  = 2;
    localparam int OFS_VALID = 3;

    typedef enum logic {
        LN_WAIT = 1'b0,
        LN_RECV = 1'b1
    } lane_state_t;

    typedef struct packed {
        logic load;
        logic complete;
        logic eof;
        logic flow;
    } lane_evt_t;
endpackage

// File: rtl/rxb_lane.sv
module rxb_lane
    import rxb_pkg::*;
#(
    parameter int LANE_W = BYTE_W,
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_tick,
    input  logic              rx_bit,
    input  logic              rx_vld,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic              data_rd,
    output logic [LANE_W-1:0] data_o,
    output lane_evt_t         evt_o
);
    localparam int CNT_W = $clog2(LANE_W + 1);

    lane_state_t       state_q, state_d;
    logic [LANE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  nbits_q;
    logic [IDLE_W-1:0] idle_q;
    logic [LANE_W-1:0] data_q;
    logic              occ_q;

    logic              take, idle_tick, expire, last_bit, flush, load, rd;
    logic [IDLE_W:0]   idle_inc;
    logic [LANE_W-1:0] shifted, partial, load_byte;

    // Datapath decode
    always_comb begin
        take      = enable & bit_tick & rx_vld;
        idle_tick = enable & bit_tick & ~rx_vld & (state_q == LN_RECV);
        idle_inc  = {1'b0, idle_q} + 1'b1;
        expire    = idle_tick & (idle_inc >= {1'b0, idle_limit});
        last_bit  = take & (nbits_q == CNT_W'(LANE_W - 1));
        shifted   = {shreg_q[LANE_W-2:0], rx_bit};
        partial   = shreg_q << (LANE_W - int'(nbits_q));
        flush     = expire & (nbits_q != '0);
        load      = last_bit | flush;
        load_byte = last_bit ? shifted : partial;
        rd        = enable & data_rd;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_WAIT: if (take)   state_d = LN_RECV;   // START
            LN_RECV: if (expire) state_d = LN_WAIT;   // TIMEOUT
            default: state_d = LN_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) state_q <= LN_WAIT;
        else                   state_q <= state_d;
    end

    // Packer, idle timer and data register
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            shreg_q <= '0;
            nbits_q <= '0;
            idle_q  <= '0;
            data_q  <= '0;
            occ_q   <= 1'b0;
        end else begin
            if (take) begin
                shreg_q <= shifted;
                nbits_q <= last_bit ? '0 : nbits_q + CNT_W'(1);
                idle_q  <= '0;
            end else if (expire) begin
                shreg_q <= '0;
                nbits_q <= '0;
                idle_q  <= '0;
            end else if (idle_tick) begin
                idle_q  <= idle_inc[IDLE_W-1:0];
            end
            if (load) begin
                data_q <= load_byte;
                occ_q  <= 1'b1;
            end else if (rd) begin
                occ_q  <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        data_o         = data_q;
        evt_o.load     = load;
        evt_o.complete = last_bit;
        evt_o.eof      = expire;
        evt_o.flow     = (load & occ_q & ~rd) | (rd & ~occ_q);
    end
endmodule

// File: rtl/rxb_status.sv
module rxb_status
    import rxb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  lane_evt_t [NUM_CH-1:0]  evt,
    input  logic                    rd_stat,
    input  logic [NUM_CH-1:0]       rd_data,
    input  logic [ST_W-1:0]         irq_en,
    output logic [ST_W-1:0]         stat_o,
    output logic                    irq_o
);
    function automatic logic [ST_W-1:0] build_mask();
        logic [ST_W-1:0] m;
        m = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            m[c*FIELD_W + OFS_FULL] = 1'b1;
            m[c*FIELD_W + OFS_EOF]  = 1'b1;
            m[c*FIELD_W + OFS_FLOW] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [ST_W-1:0] IRQ_MASK = build_mask();

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_fld
        logic [FIELD_W-1:0] fld_q;

        always_ff @(posedge clk) begin
            if (!rst_n || !enable) begin
                fld_q <= '0;
            end else begin
                fld_q[OFS_FULL] <= (fld_q[OFS_FULL] & ~(rd_stat | rd_data[ch])) | evt[ch].load;
                fld_q[OFS_EOF]  <= (fld_q[OFS_EOF]  & ~rd_stat) | evt[ch].eof;
                fld_q[OFS_FLOW] <= (fld_q[OFS_FLOW] & ~rd_stat) | evt[ch].flow;
                if (evt[ch].load) fld_q[OFS_VALID] <= evt[ch].complete;
            end
        end

        assign stat_o[ch*FIELD_W +: FIELD_W] = fld_q;
    end

    assign irq_o = |(stat_o & irq_en & IRQ_MASK);
endmodule

// File: rtl/rx_byte_hub.sv
module rx_byte_hub
    import rxb_pkg::*;
#(
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              bit_tick,
    input  logic [1:0]        rx_bit,
    input  logic [1:0]        rx_vld,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic [1:0]        host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              irq
);
    lane_evt_t [NUM_CH-1:0]             evt;
    logic      [NUM_CH-1:0][BYTE_W-1:0] lane_data;
    logic      [NUM_CH-1:0]             rd_data;
    logic      [ST_W-1:0]               stat_q;
    logic      [ST_W-1:0]               irq_en_q;
    logic                               rd_stat;

    assign rd_stat = host_rd & (host_addr == ADR_STAT);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        assign rd_data[ch] = host_rd & (host_addr == ADDR_W'(int'(ADR_DATA_A) + ch));

        rxb_lane #(.LANE_W(BYTE_W), .IDLE_W(IDLE_W)) lane_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (rx_en),
            .bit_tick   (bit_tick),
            .rx_bit     (rx_bit[ch]),
            .rx_vld     (rx_vld[ch]),
            .idle_limit (idle_limit),
            .data_rd    (rd_data[ch]),
            .data_o     (lane_data[ch]),
            .evt_o      (evt[ch])
        );
    end

    rxb_status status_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (rx_en),
        .evt     (evt),
        .rd_stat (rd_stat),
        .rd_data (rd_data),
        .irq_en  (irq_en_q),
        .stat_o  (stat_q),
        .irq_o   (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                                 irq_en_q <= '0;
        else if (host_wr && host_addr == ADR_IRQ_EN) irq_en_q <= host_wdata;
    end

    always_comb begin
        case (host_addr)
            ADR_STAT:   host_rdata = stat_q;
            ADR_DATA_A: host_rdata = lane_data[0];
            ADR_DATA_B: host_rdata = lane_data[1];
            default:    host_rdata = irq_en_q;
        endcase
    end
endmodule

// File: rtl/rxb_chk.sv
module rxb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic [1:0] host_addr,
    input logic       host_rd,
    input logic       irq,
    input logic [7:0] irq_en,
    input logic [7:0] stat,
    input logic [1:0] ev_load,
    input logic [1:0] ev_eof,
    input logic [1:0] ev_flow
);
    p_disabled_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (stat == 8'h00 && !irq));

    p_full_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_load[0] |=> stat[0]);

    p_full_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_load[1] |=> stat[4]);

    p_flow_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_flow[0] |=> stat[2]);

    p_eof_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_eof[0] |=> stat[1]);

    p_eof_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 2'd0 && !ev_eof[0]) |=> !stat[1]);

    p_valid_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_en & 8'h77) == 8'h00) |-> !irq);
endmodule

bind rx_byte_hub rxb_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .host_addr (host_addr),
    .host_rd   (host_rd),
    .irq       (irq),
    .irq_en    (irq_en_q),
    .stat      (stat_q),
    .ev_load   ({evt[1].load, evt[0].load}),
    .ev_eof    ({evt[1].eof, evt[0].eof}),
    .ev_flow   ({evt[1].flow, evt[0].flow})
);

// File: tb/rx_byte_hub_tb_top.sv
module rx_byte_hub_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       bit_tick = 1'b0;
    logic [1:0] rx_bit = '0;
    logic [1:0] rx_vld = '0;
    logic [7:0] idle_limit = 8'd200;
    logic [1:0] host_addr = '0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    rx_byte_hub dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_tick(bit_tick),
        .rx_bit(rx_bit), .rx_vld(rx_vld), .idle_limit(idle_limit),
        .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic tick(input logic [1:0] b, input logic [1:0] v);
        rx_bit = b; rx_vld = v; bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0; rx_vld = '0; rx_bit = '0;
    endtask

    task automatic send_byte(input int ch, input logic [7:0] val);
        for (int i = 7; i >= 0; i--) begin
            if (ch == 0) tick({1'b0, val[i]}, 2'b01);
            else         tick({val[i], 1'b0}, 2'b10);
        end
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic restart();
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        host_read(2'd0, d); check("R1 status after reset", d, 8'h00);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        host_read(2'd3, d); check("R10 enable reset", d, 8'h00);
        host_write(2'd3, 8'h5A);
        host_read(2'd3, d); check("R10 enable readback", d, 8'h5A);
    endtask

    task automatic t_byte_path();
        logic [7:0] d;
        restart();
        host_write(2'd3, 8'h11);
        send_byte(0, 8'hA5);
        check("R9 irq on full A", {7'b0, irq}, 8'h01);
        host_read(2'd1, d); check("R2 data A byte", d, 8'hA5);
        check("R8 irq drops after data read", {7'b0, irq}, 8'h00);
        host_read(2'd0, d); check("R8 full cleared by data read, R11 B quiet", d, 8'h08);
        send_byte(0, 8'h3C);
        host_read(2'd0, d); check("R2 full and valid set", d, 8'h09);
        check("R7 irq clear after status read", {7'b0, irq}, 8'h00);
        host_read(2'd1, d); check("R8 unread byte kept", d, 8'h3C);
        host_read(2'd1, d);
        host_write(2'd3, 8'h04);
        check("R9 irq on enabled flow bit", {7'b0, irq}, 8'h01);
        host_read(2'd0, d); check("R4 underflow flagged", d, 8'h0C);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        restart();
        send_byte(1, 8'h3C);
        send_byte(1, 8'hC3);
        host_read(2'd0, d); check("R3 overflow on B", d, 8'hD0);
        host_read(2'd2, d); check("R3 newer byte kept", d, 8'hC3);
        host_read(2'd1, d); check("R11 data A untouched", d, 8'h00);
    endtask

    task automatic t_eof();
        logic [7:0] d;
        restart();
        idle_limit = 8'd3;
        tick(2'b01, 2'b01); tick(2'b00, 2'b01); tick(2'b01, 2'b01);
        tick(2'b01, 2'b01); tick(2'b00, 2'b01);
        tick(2'b00, 2'b00); tick(2'b00, 2'b00);
        host_read(2'd0, d); check("R5 no EOF before limit", d, 8'h00);
        tick(2'b00, 2'b00);
        host_read(2'd0, d); check("R5 EOF with partial flush", d, 8'h03);
        host_read(2'd1, d); check("R5 partial left justified", d, 8'hB0);
        for (int i = 0; i < 5; i++) tick(2'b00, 2'b00);
        host_read(2'd0, d); check("R6 no repeat EOF while idle", d, 8'h00);
        tick(2'b01, 2'b01);
        tick(2'b00, 2'b00); tick(2'b00, 2'b00); tick(2'b00, 2'b00);
        host_read(2'd0, d); check("R6 new frame ends again", d, 8'h03);
        host_read(2'd1, d); check("R6 one-bit partial", d, 8'h80);
        idle_limit = 8'd200;
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        restart();
        for (int i = 0; i < 7; i++) tick(2'b01, 2'b01);
        host_addr = 2'd0; host_rd = 1'b1;
        rx_bit = 2'b01; rx_vld = 2'b01; bit_tick = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0; bit_tick = 1'b0; rx_vld = '0; rx_bit = '0;
        check("R7 status before set", d, 8'h00);
        host_read(2'd0, d); check("R7 set wins over read clear", d, 8'h09);
    endtask

    task automatic t_valid_mask();
        logic [7:0] d;
        restart();
        host_write(2'd3, 8'h88);
        send_byte(0, 8'h00);
        check("R9 valid bits never raise irq", {7'b0, irq}, 8'h00);
        host_read(2'd0, d); check("R9 status set without enable", d, 8'h09);
    endtask

    task automatic t_disable();
        logic [7:0] d;
        restart();
        host_write(2'd3, 8'h11);
        send_byte(0, 8'h77);
        rx_en = 1'b0;
        @(negedge clk);
        check("R1 irq low while disabled", {7'b0, irq}, 8'h00);
        host_read(2'd0, d); check("R1 status reads zero disabled", d, 8'h00);
        host_read(2'd1, d); check("R1 data discarded", d, 8'h00);
        rx_en = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=0x00 expected=0x01");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rx_en = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_path();
        t_overflow();
        t_eof();
        t_set_wins();
        t_valid_mask();
        t_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule